// File: doc/BRIEF.md
# Prioritised Address Window Translator

This block maps an incoming address onto an outbound address space through eight programmable windows. Each window has an enable flag, an inclusive lower bound, an inclusive upper bound and an additive offset. Each lookup compares the presented address against every window in parallel. The lowest-numbered enabled window whose range contains the address is selected, and its offset is added to the address. When no window claims the address, a miss is reported so that the surrounding logic can refuse the cycle.

The windows are programmed through a plain word-addressed register port. Writes are synchronous and reads are combinational. The result of each lookup appears on registered outputs one cycle after the request. Bus protocol handling sits outside this block.

Top module: `addr_window_xlat`

## Requirements
- R1: After synchronous reset, every configuration register reads back as zero, all windows are disabled, and `rs_valid` and `rs_hit` are low.
- R2: Configuration word address = 4 × window + field. Field 0 is control: bit 0 is the enable, and the other bits read back as zero. Field 1 is the lower bound, field 2 the upper bound and field 3 the offset. `cfg_rdata` shows the register selected by `cfg_addr` in the same cycle.
- R3: An enabled window contains an address when lower bound ≤ address ≤ upper bound. Both bounds are inclusive, so an address one below the lower bound or one above the upper bound falls outside.
- R4: On a hit, `rs_addr` equals the lookup address plus the selected window's offset, taken modulo 2^32.
- R5: When several enabled windows contain the address, the window with the lowest index is reported in `rs_win` and supplies the offset.
- R6: A window whose enable bit is 0 never hits, whatever its bounds.
- R7: A window whose lower bound exceeds its upper bound never hits.
- R8: On a miss, `rs_valid` is 1, and `rs_hit`, `rs_win` and `rs_addr` are all 0.
- R9: `rs_valid` is high exactly in the cycle after a cycle with `lk_valid` high. In a cycle where `rs_valid` is low, `rs_hit` is low.
- R10: A register write is used by lookups presented in later cycles. A lookup presented in the same cycle as a write uses the settings from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Configuration word address |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data (combinational) |
| lk_valid | input | 1 | Lookup request valid |
| lk_addr | input | 32 | Lookup address |
| rs_valid | output | 1 | Result valid, one cycle after the request |
| rs_hit | output | 1 | A window claimed the address |
| rs_win | output | 3 | Index of the winning window |
| rs_addr | output | 32 | Translated address |

## Verification
Each window's bounds are probed at the bound itself, one step inside it and one step outside it, plus a midpoint. These probes separate inclusive comparisons from exclusive ones. Overlapping windows and a catch-all window at the lowest priority show whether the lowest index wins. Sweeps are repeated after the catch-all is removed and after enables are toggled, which exposes misses, disabled windows and inverted ranges. Offsets that carry past the top of the address space check the modular sum. A write presented together with a lookup separates old settings from new ones.

// File: rtl/awt_pkg.sv
package awt_pkg;

    // Register field selector: low two bits of the configuration word address.
    typedef enum logic [1:0] {
        FLD_CTRL   = 2'd0,
        FLD_LOWER  = 2'd1,
        FLD_UPPER  = 2'd2,
        FLD_OFFSET = 2'd3
    } awt_field_e;

    localparam int unsigned FIELDS_PER_WIN = 4;
    localparam int unsigned FIELD_BITS     = 2;
    localparam int unsigned CTRL_EN_BIT    = 0;

    // Extract the field selector from a configuration word address.
    function automatic awt_field_e field_of(input logic [FIELD_BITS-1:0] low_bits);
        return awt_field_e'(low_bits);
    endfunction

endpackage

// File: rtl/awt_regfile.sv
module awt_regfile
    import awt_pkg::*;
#(
    parameter int NUM_WIN = 8,
    parameter int ADDR_W  = 32,
    parameter int CFG_AW  = 5
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            cfg_we,
    input  logic [CFG_AW-1:0]               cfg_addr,
    input  logic [ADDR_W-1:0]               cfg_wdata,
    output logic [ADDR_W-1:0]               cfg_rdata,
    output logic [NUM_WIN-1:0]              win_en,
    output logic [NUM_WIN-1:0][ADDR_W-1:0]  win_lo,
    output logic [NUM_WIN-1:0][ADDR_W-1:0]  win_hi,
    output logic [NUM_WIN-1:0][ADDR_W-1:0]  win_off
);
    localparam int IDX_W = CFG_AW - FIELD_BITS;

    logic [IDX_W-1:0] sel_idx;
    awt_field_e       sel_fld;

    assign sel_idx = cfg_addr[CFG_AW-1:FIELD_BITS];
    assign sel_fld = field_of(cfg_addr[FIELD_BITS-1:0]);

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        logic hit_w;
        assign hit_w = cfg_we && (sel_idx == IDX_W'(w));

        always_ff @(posedge clk) begin
            if (rst) begin
                win_en[w]  <= 1'b0;
                win_lo[w]  <= '0;
                win_hi[w]  <= '0;
                win_off[w] <= '0;
            end else if (hit_w) begin
                case (sel_fld)
                    FLD_CTRL:   win_en[w]  <= cfg_wdata[CTRL_EN_BIT];
                    FLD_LOWER:  win_lo[w]  <= cfg_wdata;
                    FLD_UPPER:  win_hi[w]  <= cfg_wdata;
                    FLD_OFFSET: win_off[w] <= cfg_wdata;
                    default:    ;
                endcase
            end
        end
    end

    always_comb begin
        cfg_rdata = '0;
        for (int w = 0; w < NUM_WIN; w++) begin
            if (sel_idx == IDX_W'(w)) begin
                case (sel_fld)
                    FLD_CTRL:   cfg_rdata = {{(ADDR_W-1){1'b0}}, win_en[w]};
                    FLD_LOWER:  cfg_rdata = win_lo[w];
                    FLD_UPPER:  cfg_rdata = win_hi[w];
                    FLD_OFFSET: cfg_rdata = win_off[w];
                    default:    cfg_rdata = '0;
                endcase
            end
        end
    end

endmodule

// File: rtl/awt_match.sv
module awt_match #(
    parameter int NUM_WIN = 8,
    parameter int ADDR_W  = 32
) (
    input  logic [ADDR_W-1:0]               addr,
    input  logic [NUM_WIN-1:0]              win_en,
    input  logic [NUM_WIN-1:0][ADDR_W-1:0]  win_lo,
    input  logic [NUM_WIN-1:0][ADDR_W-1:0]  win_hi,
    output logic [NUM_WIN-1:0]              match
);
    // One inclusive range comparator per window; an inverted range is empty.
    for (genvar w = 0; w < NUM_WIN; w++) begin : g_cmp
        logic ge_lo, le_hi;
        assign ge_lo    = (addr >= win_lo[w]);
        assign le_hi    = (addr <= win_hi[w]);
        assign match[w] = win_en[w] && ge_lo && le_hi;
    end

endmodule

// File: rtl/awt_prio.sv
module awt_prio #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    // Fixed priority: scanning downward leaves the lowest set index in idx.
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end

    assign any = |req;

endmodule

// File: rtl/addr_window_xlat.sv
module addr_window_xlat
    import awt_pkg::*;
#(
    parameter  int NUM_WIN = 8,
    parameter  int ADDR_W  = 32,
    localparam int WIN_W   = $clog2(NUM_WIN),
    localparam int CFG_AW  = $clog2(NUM_WIN * FIELDS_PER_WIN)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [ADDR_W-1:0] cfg_wdata,
    output logic [ADDR_W-1:0] cfg_rdata,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              rs_valid,
    output logic              rs_hit,
    output logic [WIN_W-1:0]  rs_win,
    output logic [ADDR_W-1:0] rs_addr
);
    logic [NUM_WIN-1:0]              win_en;
    logic [NUM_WIN-1:0][ADDR_W-1:0]  win_lo;
    logic [NUM_WIN-1:0][ADDR_W-1:0]  win_hi;
    logic [NUM_WIN-1:0][ADDR_W-1:0]  win_off;
    logic [NUM_WIN-1:0]              match;
    logic                            any_hit;
    logic [WIN_W-1:0]                win_sel;
    logic [ADDR_W-1:0]               off_sel;
    logic [ADDR_W-1:0]               xlat;
    logic                            take;

    awt_regfile #(
        .NUM_WIN (NUM_WIN),
        .ADDR_W  (ADDR_W),
        .CFG_AW  (CFG_AW)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .win_en    (win_en),
        .win_lo    (win_lo),
        .win_hi    (win_hi),
        .win_off   (win_off)
    );

    awt_match #(
        .NUM_WIN (NUM_WIN),
        .ADDR_W  (ADDR_W)
    ) u_match (
        .addr   (lk_addr),
        .win_en (win_en),
        .win_lo (win_lo),
        .win_hi (win_hi),
        .match  (match)
    );

    awt_prio #(
        .N  (NUM_WIN),
        .IW (WIN_W)
    ) u_prio (
        .req (match),
        .any (any_hit),
        .idx (win_sel)
    );

    // Offset of the winning window, then a modular add.
    always_comb begin
        off_sel = '0;
        for (int w = 0; w < NUM_WIN; w++) begin
            if (win_sel == WIN_W'(w)) off_sel = win_off[w];
        end
    end

    assign xlat = lk_addr + off_sel;
    assign take = lk_valid && any_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            rs_valid <= 1'b0;
            rs_hit   <= 1'b0;
            rs_win   <= '0;
            rs_addr  <= '0;
        end else begin
            rs_valid <= lk_valid;
            rs_hit   <= take;
            rs_win   <= take ? win_sel : '0;
            rs_addr  <= take ? xlat : '0;
        end
    end

endmodule

// File: rtl/awt_chk.sv
module awt_chk #(
    parameter int NUM_WIN = 8,
    parameter int ADDR_W  = 32,
    parameter int WIN_W   = 3
) (
    input logic                            clk,
    input logic                            rst,
    input logic                            lk_valid,
    input logic [ADDR_W-1:0]               lk_addr,
    input logic                            rs_valid,
    input logic                            rs_hit,
    input logic [WIN_W-1:0]                rs_win,
    input logic [ADDR_W-1:0]               rs_addr,
    input logic [NUM_WIN-1:0]              win_en,
    input logic [NUM_WIN-1:0][ADDR_W-1:0]  win_lo,
    input logic [NUM_WIN-1:0][ADDR_W-1:0]  win_hi,
    input logic [NUM_WIN-1:0][ADDR_W-1:0]  win_off
);
    // Snapshot of the request and the settings it saw, aligned with the result.
    logic [ADDR_W-1:0]              d_addr;
    logic [NUM_WIN-1:0]             d_en;
    logic [NUM_WIN-1:0][ADDR_W-1:0] d_lo, d_hi, d_off;
    logic [NUM_WIN-1:0]             d_in;
    logic [NUM_WIN-1:0]             below;

    always_ff @(posedge clk) begin
        d_addr <= lk_addr;
        d_en   <= win_en;
        d_lo   <= win_lo;
        d_hi   <= win_hi;
        d_off  <= win_off;
    end

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_in
        assign d_in[w] = d_en[w] && (d_addr >= d_lo[w]) && (d_addr <= d_hi[w]);
    end

    assign below = (NUM_WIN'(1) << rs_win) - NUM_WIN'(1);

    // R9
    result_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> rs_valid);

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |=> (!rs_valid && !rs_hit));

    // R8
    miss_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !rs_hit |-> (rs_win == '0 && rs_addr == '0));

    // R3 R6 R7
    hit_inside_chk: assert property (@(posedge clk) disable iff (rst)
        rs_hit |-> d_in[rs_win]);

    // R4
    xlat_sum_chk: assert property (@(posedge clk) disable iff (rst)
        rs_hit |-> (rs_addr == d_addr + d_off[rs_win]));

    // R5
    lowest_wins_chk: assert property (@(posedge clk) disable iff (rst)
        rs_hit |-> ((d_in & below) == '0));

    // R8
    miss_empty_chk: assert property (@(posedge clk) disable iff (rst)
        (rs_valid && !rs_hit) |-> (d_in == '0));

endmodule

bind addr_window_xlat awt_chk #(
    .NUM_WIN (NUM_WIN),
    .ADDR_W  (ADDR_W),
    .WIN_W   (WIN_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .lk_valid (lk_valid),
    .lk_addr  (lk_addr),
    .rs_valid (rs_valid),
    .rs_hit   (rs_hit),
    .rs_win   (rs_win),
    .rs_addr  (rs_addr),
    .win_en   (win_en),
    .win_lo   (win_lo),
    .win_hi   (win_hi),
    .win_off  (win_off)
);

// File: tb/sim_addr_window_xlat.sv
module sim_addr_window_xlat;
    localparam int CLK_PERIOD = 10;
    localparam int NW = 8;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic [4:0]  cfg_addr;
    logic [31:0] cfg_wdata;
    logic [31:0] cfg_rdata;
    logic        lk_valid;
    logic [31:0] lk_addr;
    logic        rs_valid;
    logic        rs_hit;
    logic [2:0]  rs_win;
    logic [31:0] rs_addr;

    int checks = 0;
    int errors = 0;

    logic        sh_en  [NW];
    logic [31:0] sh_lo  [NW];
    logic [31:0] sh_hi  [NW];
    logic [31:0] sh_off [NW];

    always #(CLK_PERIOD/2) clk = ~clk;

    addr_window_xlat u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .lk_valid(lk_valid),
        .lk_addr(lk_addr), .rs_valid(rs_valid), .rs_hit(rs_hit),
        .rs_win(rs_win), .rs_addr(rs_addr)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Reference model built from R3 R4 R5 R6 R7.
    task automatic model(input logic [31:0] a, output bit hit, output int win,
                         output logic [31:0] xa, output int nmatch);
        hit = 0; win = 0; xa = '0; nmatch = 0;
        for (int w = NW - 1; w >= 0; w--) begin
            if (sh_en[w] && a >= sh_lo[w] && a <= sh_hi[w]) begin
                hit = 1; win = w; xa = a + sh_off[w]; nmatch++;
            end
        end
    endtask

    task automatic wr(input int w, input int f, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 5'(w * 4 + f); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        case (f)
            0: sh_en[w]  = d[0];
            1: sh_lo[w]  = d;
            2: sh_hi[w]  = d;
            default: sh_off[w] = d;
        endcase
    endtask

    task automatic rd_check(input int w, input int f, input string req);
        logic [31:0] exp;
        cfg_addr = 5'(w * 4 + f);
        #1;
        case (f)
            0: exp = {31'b0, sh_en[w]};
            1: exp = sh_lo[w];
            2: exp = sh_hi[w];
            default: exp = sh_off[w];
        endcase
        check(cfg_rdata === exp, req, $sformatf("readback w%0d f%0d", w, f),
              64'(cfg_rdata), 64'(exp));
    endtask

    task automatic look(input logic [31:0] a, input string tag);
        bit hit; int win; logic [31:0] xa; int nm; string req;
        model(a, hit, win, xa, nm);
        @(negedge clk);
        lk_valid = 1'b1; lk_addr = a;
        @(negedge clk);
        lk_valid = 1'b0;
        if (tag != "") req = tag;
        else if (!hit) req = "R8";
        else if (nm > 1) req = "R5";
        else if (a == sh_lo[win] || a == sh_hi[win]) req = "R3";
        else req = "R4";
        check(rs_valid === 1'b1, "R9", $sformatf("valid a=%h", a), 64'(rs_valid), 64'd1);
        check(rs_hit === hit && rs_win === 3'(win) && rs_addr === xa, req,
              $sformatf("result a=%h {hit,win,addr}", a),
              {28'b0, rs_hit, rs_win, rs_addr}, {28'b0, hit, 3'(win), xa});
    endtask

    task automatic sweep();
        for (int w = 0; w < NW; w++) begin
            look(sh_lo[w] - 32'd1, "");
            look(sh_lo[w], "");
            look(sh_lo[w] + 32'd1, "");
            look(sh_lo[w] + ((sh_hi[w] - sh_lo[w]) >> 1), "");
            look(sh_hi[w] - 32'd1, "");
            look(sh_hi[w], "");
            look(sh_hi[w] + 32'd1, "");
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int w = 0; w < NW; w++) begin
            sh_en[w] = 0; sh_lo[w] = '0; sh_hi[w] = '0; sh_off[w] = '0;
        end
        rst = 1'b1; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        lk_valid = 1'b0; lk_addr = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        check(rs_valid === 1'b0 && rs_hit === 1'b0, "R1", "outputs idle after reset",
              64'({rs_valid, rs_hit}), 64'd0);
        for (int w = 0; w < NW; w++)
            for (int f = 0; f < 4; f++) rd_check(w, f, "R1");
        look(32'h0000_1234, "R1");

        // R2: control keeps only the enable bit
        wr(3, 0, 32'hFFFF_FFFE);
        rd_check(3, 0, "R2");
        wr(3, 0, 32'hFFFF_FFFF);
        rd_check(3, 0, "R2");

        // Overlapping configuration with a catch-all at the lowest priority.
        wr(0, 1, 32'h0000_1000); wr(0, 2, 32'h0000_1FFF); wr(0, 3, 32'h1000_0000); wr(0, 0, 1);
        wr(1, 1, 32'h0000_1800); wr(1, 2, 32'h0000_2FFF); wr(1, 3, 32'h2000_0000); wr(1, 0, 1);
        wr(2, 1, 32'h0000_0000); wr(2, 2, 32'h0000_00FF); wr(2, 3, 32'h0000_0005); wr(2, 0, 1);
        wr(3, 1, 32'h0000_4000); wr(3, 2, 32'h0000_4FFF); wr(3, 3, 32'h0000_0007); wr(3, 0, 0);
        wr(4, 1, 32'h0000_9000); wr(4, 2, 32'h0000_8000); wr(4, 3, 32'h0000_0100); wr(4, 0, 1);
        wr(5, 1, 32'h0000_4800); wr(5, 2, 32'h0000_5000); wr(5, 3, 32'hFFFF_F000); wr(5, 0, 1);
        wr(6, 1, 32'hFFFF_FF00); wr(6, 2, 32'hFFFF_FFFF); wr(6, 3, 32'h0000_0200); wr(6, 0, 1);
        wr(7, 1, 32'h0000_0000); wr(7, 2, 32'hFFFF_FFFF); wr(7, 3, 32'h7000_0000); wr(7, 0, 1);

        // R2: full readback of the programmed map
        for (int w = 0; w < NW; w++)
            for (int f = 0; f < 4; f++) rd_check(w, f, "R2");

        // R5: catch-all present, every probe hits
        sweep();
        // R4: carries past the top of the space
        look(32'hFFFF_FF80, "R4");
        look(32'h0000_4900, "R4");

        // R9: a cycle with no request leaves the result low
        @(negedge clk);
        check(rs_valid === 1'b0 && rs_hit === 1'b0, "R9", "no request -> idle",
              64'({rs_valid, rs_hit}), 64'd0);

        // Remove the catch-all: misses, disabled and inverted windows show.
        wr(7, 0, 0);
        sweep();
        look(32'h0000_4000, "R6");
        look(32'h0000_4400, "R6");
        look(32'h0000_8000, "R7");
        look(32'h0000_8800, "R7");
        look(32'h0000_9000, "R7");
        look(32'h7777_0000, "R8");

        // R6: swap enables, priority moves to the remaining window
        wr(3, 0, 1); wr(0, 0, 0);
        sweep();
        look(32'h0000_1900, "R6");

        // R10: write and lookup in the same cycle use the old settings
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 5'(7 * 4); cfg_wdata = 32'h1;
        lk_valid = 1'b1; lk_addr = 32'h7777_0000;
        @(negedge clk);
        cfg_we = 1'b0; lk_valid = 1'b0;
        check(rs_valid === 1'b1 && rs_hit === 1'b0, "R10", "same-cycle lookup uses old map",
              64'({rs_valid, rs_hit}), 64'({1'b1, 1'b0}));
        sh_en[7] = 1'b1;
        look(32'h7777_0000, "R10");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule